// File: doc/BRIEF.md
# Configurable PLD Macrocell Bank

This block is a group of logic cells of the sort that sit behind a sum-of-products array in a complex programmable logic device. Each cell takes one sum-term bit. Static configuration decides how that bit is handled: it can pass straight through, go through a level-sensitive latch, or be stored in a D or a T flip-flop. Configuration also sets whether the output is true or inverted, and which of two global clock strobes drives the storage element. Each cell produces a pin data value, a pin drive enable, and a feedback bit for the array. The feedback bit can be taken from the cell itself or from the pad.

The cells in one group share a single output-enable input. A parameter mask marks some cells as buried-capable. When such a cell is told to capture its pad, it stops driving the pin. It then stores the external pad value instead of the sum term, which gives an input register or input latch for synchronising outside signals.

The design runs on one system clock `clk`. The two global clocks `gclk0` and `gclk1` are level strobes that this clock samples. A register mode acts on a `clk` edge at which the selected strobe is high. A latch is transparent while the selected strobe is high. The synchronous active-high `rst` clears every storage element.

Top module: `mc_bank`

## Requirements
- R1: A `clk` edge with `rst` high clears every cell's stored bit to 0. Afterwards, a cell in a storage mode with strobes low drives `pin_o` equal to its `cfg_inv` bit.
- R2: Mode code 2'b00 (combinational) makes `pin_o[i]` equal to the data source XOR `cfg_inv[i]` in the same cycle, with no clock involvement.
- R3: Mode code 2'b10 (D register): on a `clk` edge where the selected strobe is high, the data source is stored. On edges where the strobe is low, the stored bit holds.
- R4: Mode code 2'b11 (T register): on a `clk` edge where the selected strobe is high, the stored bit inverts when the data source is 1 and holds when it is 0.
- R5: Mode code 2'b01 (latch): while the selected strobe is high, `pin_o[i]` follows the data source in the same cycle. While the strobe is low, it shows the last value passed.
- R6: `cfg_clk_sel[i]`=0 selects `gclk0` and 1 selects `gclk1`. The unselected strobe has no effect on the cell.
- R7: Inversion is applied after storage. Changing `cfg_inv[i]` flips `pin_o[i]` immediately and leaves the stored bit unchanged.
- R8: A cell that is not capturing drives `pin_oe[i]` equal to the shared `oe` input.
- R9: A cell whose `CAP_MASK` bit is 1 and whose `cfg_in_cap[i]` is 1 uses `pin_i[i]` as its data source in every mode and holds `pin_oe[i]` at 0.
- R10: A cell whose `CAP_MASK` bit is 0 ignores `cfg_in_cap[i]`. It keeps the sum term as its data source and keeps following `oe`.
- R11: `fb[i]` equals `pin_i[i]` when `cfg_fb_pin[i]` is 1, and equals the cell's output value `pin_o[i]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all stored bits |
| gclk0 | input | 1 | Global clock strobe 0 |
| gclk1 | input | 1 | Global clock strobe 1 |
| oe | input | 1 | Shared output enable of the group |
| sum | input | CELLS | Sum-term bit per cell |
| pin_i | input | CELLS | Pad value seen at each pin |
| cfg_mode | input | 2*CELLS | Mode code per cell: 00 comb, 01 latch, 10 D, 11 T |
| cfg_inv | input | CELLS | Output inversion per cell |
| cfg_clk_sel | input | CELLS | Strobe select per cell |
| cfg_in_cap | input | CELLS | Capture pad instead of sum (buried-capable cells only) |
| cfg_fb_pin | input | CELLS | Feedback taken from pad instead of cell |
| pin_o | output | CELLS | Cell output value toward the pin |
| pin_oe | output | CELLS | Pin drive enable |
| fb | output | CELLS | Feedback bit toward the array |

## Verification
The bench puts the same stored bit behind each mode change. A design that stored the inverted value, instead of inverting after storage, would show the wrong level once `cfg_inv` toggles. A design that always followed `gclk0` is caught by strobing only the unselected clock and seeing the value move. The same kind of check catches a latch that captured on an edge instead of passing data through at once. In the T mode, repeated strobes with a 1 and then a 0 show both toggling and holding, and a D-style capture would fail that check. Buried-capable and plain cells both get the capture bit set. A mask decoded backwards would then drive the pin, or take the pad value, on the wrong cell.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MD_COMB  = 2'b00,
    MD_LATCH = 2'b01,
    MD_DREG  = 2'b10,
    MD_TREG  = 2'b11
  } mc_mode_e;
endpackage

// File: rtl/mc_strobe_sel.sv
module mc_strobe_sel (
  input  logic gclk0,
  input  logic gclk1,
  input  logic sel,
  output logic strobe
);
  always_comb begin
    strobe = sel ? gclk1 : gclk0;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mc_mode_e mode,
  input  logic     strobe,
  input  logic     d,
  output logic     val
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (strobe) begin
      case (mode)
        MD_TREG: q <= q ^ d;
        default: q <= d;
      endcase
    end
  end

  always_comb begin
    case (mode)
      MD_COMB:  val = d;
      MD_LATCH: val = strobe ? d : q;
      default:  val = q;
    endcase
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter bit CAN_CAPTURE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gclk0,
  input  logic       gclk1,
  input  logic       oe,
  input  logic       sum,
  input  logic       pin_i,
  input  logic [1:0] mode,
  input  logic       inv,
  input  logic       clk_sel,
  input  logic       in_cap,
  input  logic       fb_pin,
  output logic       pin_o,
  output logic       pin_oe,
  output logic       fb
);
  logic strobe;
  logic capturing;
  logic d_src;
  logic stored_val;

  mc_strobe_sel u_sel (
    .gclk0  (gclk0),
    .gclk1  (gclk1),
    .sel    (clk_sel),
    .strobe (strobe)
  );

  generate
    if (CAN_CAPTURE) begin : g_cap
      assign capturing = in_cap;
    end else begin : g_nocap
      assign capturing = 1'b0;
    end
  endgenerate

  assign d_src = capturing ? pin_i : sum;

  mc_store u_store (
    .clk    (clk),
    .rst    (rst),
    .mode   (mc_mode_e'(mode)),
    .strobe (strobe),
    .d      (d_src),
    .val    (stored_val)
  );

  always_comb begin
    pin_o  = stored_val ^ inv;
    pin_oe = oe & ~capturing;
    fb     = fb_pin ? pin_i : pin_o;
  end
endmodule

// File: rtl/mc_bank.sv
module mc_bank #(
  parameter int                CELLS    = 8,
  parameter logic [CELLS-1:0]  CAP_MASK = 8'hF0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gclk0,
  input  logic                 gclk1,
  input  logic                 oe,
  input  logic [CELLS-1:0]     sum,
  input  logic [CELLS-1:0]     pin_i,
  input  logic [2*CELLS-1:0]   cfg_mode,
  input  logic [CELLS-1:0]     cfg_inv,
  input  logic [CELLS-1:0]     cfg_clk_sel,
  input  logic [CELLS-1:0]     cfg_in_cap,
  input  logic [CELLS-1:0]     cfg_fb_pin,
  output logic [CELLS-1:0]     pin_o,
  output logic [CELLS-1:0]     pin_oe,
  output logic [CELLS-1:0]     fb
);
  localparam int MODE_W = 2;

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      mc_cell #(
        .CAN_CAPTURE (CAP_MASK[i])
      ) u_cell (
        .clk     (clk),
        .rst     (rst),
        .gclk0   (gclk0),
        .gclk1   (gclk1),
        .oe      (oe),
        .sum     (sum[i]),
        .pin_i   (pin_i[i]),
        .mode    (cfg_mode[MODE_W*i +: MODE_W]),
        .inv     (cfg_inv[i]),
        .clk_sel (cfg_clk_sel[i]),
        .in_cap  (cfg_in_cap[i]),
        .fb_pin  (cfg_fb_pin[i]),
        .pin_o   (pin_o[i]),
        .pin_oe  (pin_oe[i]),
        .fb      (fb[i])
      );
    end
  endgenerate
endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk #(
  parameter int               CELLS    = 8,
  parameter logic [CELLS-1:0] CAP_MASK = 8'hF0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gclk0,
  input logic                 gclk1,
  input logic                 oe,
  input logic [CELLS-1:0]     sum,
  input logic [CELLS-1:0]     pin_i,
  input logic [2*CELLS-1:0]   cfg_mode,
  input logic [CELLS-1:0]     cfg_inv,
  input logic [CELLS-1:0]     cfg_clk_sel,
  input logic [CELLS-1:0]     cfg_in_cap,
  input logic [CELLS-1:0]     cfg_fb_pin,
  input logic [CELLS-1:0]     pin_o,
  input logic [CELLS-1:0]     pin_oe,
  input logic [CELLS-1:0]     fb
);
  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_chk
      logic [1:0] md;
      logic       cap;
      logic       stb;
      logic       src;
      assign md  = cfg_mode[2*i +: 2];
      assign cap = CAP_MASK[i] & cfg_in_cap[i];
      assign stb = cfg_clk_sel[i] ? gclk1 : gclk0;
      assign src = cap ? pin_i[i] : sum[i];

      // R2
      p_comb_path_r2: assert property (@(posedge clk) disable iff (rst)
        (md == 2'b00) |-> (pin_o[i] == (src ^ cfg_inv[i])));

      // R3
      p_dreg_load_r3: assert property (@(posedge clk) disable iff (rst)
        (md == 2'b10 && stb) |=>
        (md != 2'b10 || !$stable(cfg_inv[i]) || !$stable(cap) ||
         pin_o[i] == ($past(src) ^ cfg_inv[i])));

      // R4
      p_tog_r4: assert property (@(posedge clk) disable iff (rst)
        (md == 2'b11 && stb && src) |=>
        (md != 2'b11 || !$stable(cfg_inv[i]) || !$stable(cap) ||
         pin_o[i] != $past(pin_o[i])));

      // R8, R9
      p_oe_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !cap |-> (pin_oe[i] == oe));
      p_cap_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
        cap |-> !pin_oe[i]);

      // R11
      p_fb_pad_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_fb_pin[i] |-> (fb[i] == pin_i[i]));
      p_fb_cell_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_fb_pin[i] |-> (fb[i] == pin_o[i]));
    end
  endgenerate
endmodule

bind mc_bank mc_bank_chk #(.CELLS(CELLS), .CAP_MASK(CAP_MASK)) u_chk (
  .clk(clk), .rst(rst), .gclk0(gclk0), .gclk1(gclk1), .oe(oe),
  .sum(sum), .pin_i(pin_i), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
  .cfg_clk_sel(cfg_clk_sel), .cfg_in_cap(cfg_in_cap),
  .cfg_fb_pin(cfg_fb_pin), .pin_o(pin_o), .pin_oe(pin_oe), .fb(fb)
);

// File: tb/mc_bank_test.sv
module mc_bank_test;
  localparam int N = 8;
  localparam int CC = 0;   // plain cell
  localparam int CB = 4;   // buried-capable cell

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gclk0 = 1'b0, gclk1 = 1'b0, oe = 1'b0;
  logic [N-1:0]   sum = '0, pin_i = '0, cfg_inv = '0, cfg_clk_sel = '0;
  logic [N-1:0]   cfg_in_cap = '0, cfg_fb_pin = '0;
  logic [2*N-1:0] cfg_mode = '0;
  logic [N-1:0]   pin_o, pin_oe, fb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc_bank #(.CELLS(N), .CAP_MASK(8'hF0)) uut (
    .clk(clk), .rst(rst), .gclk0(gclk0), .gclk1(gclk1), .oe(oe),
    .sum(sum), .pin_i(pin_i), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
    .cfg_clk_sel(cfg_clk_sel), .cfg_in_cap(cfg_in_cap),
    .cfg_fb_pin(cfg_fb_pin), .pin_o(pin_o), .pin_oe(pin_oe), .fb(fb)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    gclk0 = 0; gclk1 = 0; rst = 1;
    tick();
    rst = 0;
  endtask

  task automatic set_mode(int c, logic [1:0] m);
    cfg_mode[2*c +: 2] = m;
  endtask

  task automatic t_reset_r1();
    for (int c = 0; c < N; c++) set_mode(c, 2'b10);
    sum = '1; cfg_inv = '0;
    do_reset();
    chk("R1 cleared", pin_o, '0);
    cfg_inv = '1; #1;
    chk("R1 inverted zero", pin_o, '1);
    cfg_inv = '0;
  endtask

  task automatic t_comb_r2();
    set_mode(CC, 2'b00);
    sum[CC] = 1; #1; chk("R2 pass 1", N'(pin_o[CC]), N'(1));
    sum[CC] = 0; #1; chk("R2 pass 0", N'(pin_o[CC]), N'(0));
    cfg_inv[CC] = 1; #1; chk("R2 inv", N'(pin_o[CC]), N'(1));
    cfg_inv[CC] = 0;
  endtask

  task automatic t_dreg_r3();
    do_reset(); set_mode(CC, 2'b10);
    sum[CC] = 1; gclk0 = 1; tick();
    chk("R3 load 1", N'(pin_o[CC]), N'(1));
    gclk0 = 0; sum[CC] = 0; tick();
    chk("R3 hold", N'(pin_o[CC]), N'(1));
    gclk0 = 1; tick();
    chk("R3 load 0", N'(pin_o[CC]), N'(0));
    gclk0 = 0;
  endtask

  task automatic t_treg_r4();
    do_reset(); set_mode(CC, 2'b11);
    sum[CC] = 1; gclk0 = 1;
    tick(); chk("R4 toggle a", N'(pin_o[CC]), N'(1));
    tick(); chk("R4 toggle b", N'(pin_o[CC]), N'(0));
    tick(); chk("R4 toggle c", N'(pin_o[CC]), N'(1));
    sum[CC] = 0;
    tick(); chk("R4 hold", N'(pin_o[CC]), N'(1));
    gclk0 = 0;
  endtask

  task automatic t_latch_r5();
    do_reset(); set_mode(CC, 2'b01);
    gclk0 = 1; sum[CC] = 1; #1;
    chk("R5 transparent 1", N'(pin_o[CC]), N'(1));
    sum[CC] = 0; #1;
    chk("R5 transparent 0", N'(pin_o[CC]), N'(0));
    sum[CC] = 1; tick();
    gclk0 = 0; sum[CC] = 0; #1;
    chk("R5 closed", N'(pin_o[CC]), N'(1));
    tick();
    chk("R5 still closed", N'(pin_o[CC]), N'(1));
  endtask

  task automatic t_clksel_r6();
    do_reset(); set_mode(CC, 2'b10); cfg_clk_sel[CC] = 1;
    sum[CC] = 1; gclk0 = 1; tick();
    chk("R6 other strobe ignored", N'(pin_o[CC]), N'(0));
    gclk0 = 0; gclk1 = 1; tick();
    chk("R6 selected strobe", N'(pin_o[CC]), N'(1));
    gclk1 = 0; cfg_clk_sel[CC] = 0;
  endtask

  task automatic t_pol_r7();
    do_reset(); set_mode(CC, 2'b10);
    sum[CC] = 1; gclk0 = 1; tick(); gclk0 = 0;
    cfg_inv[CC] = 1; #1;
    chk("R7 inverted", N'(pin_o[CC]), N'(0));
    tick();
    cfg_inv[CC] = 0; #1;
    chk("R7 state kept", N'(pin_o[CC]), N'(1));
  endtask

  task automatic t_oe_r8();
    cfg_in_cap = '0;
    oe = 1; #1; chk("R8 oe high", pin_oe, '1);
    oe = 0; #1; chk("R8 oe low", pin_oe, '0);
  endtask

  task automatic t_cap_r9();
    do_reset(); oe = 1; set_mode(CB, 2'b10); cfg_in_cap[CB] = 1;
    sum[CB] = 0; pin_i[CB] = 1; gclk0 = 1; tick(); gclk0 = 0;
    chk("R9 pad stored", N'(pin_o[CB]), N'(1));
    chk("R9 no drive", N'(pin_oe[CB]), N'(0));
    set_mode(CB, 2'b01); gclk0 = 1; pin_i[CB] = 0; sum[CB] = 1; #1;
    chk("R9 pad latch", N'(pin_o[CB]), N'(0));
    gclk0 = 0; cfg_in_cap[CB] = 0; oe = 0;
  endtask

  task automatic t_nocap_r10();
    do_reset(); oe = 1; set_mode(CC, 2'b10); cfg_in_cap[CC] = 1;
    sum[CC] = 1; pin_i[CC] = 0; gclk0 = 1; tick(); gclk0 = 0;
    chk("R10 sum stored", N'(pin_o[CC]), N'(1));
    chk("R10 still drives", N'(pin_oe[CC]), N'(1));
    cfg_in_cap[CC] = 0; oe = 0;
  endtask

  task automatic t_fb_r11();
    do_reset(); set_mode(CC, 2'b00); sum[CC] = 0; pin_i[CC] = 1;
    cfg_fb_pin[CC] = 1; #1;
    chk("R11 pad feedback", N'(fb[CC]), N'(1));
    cfg_fb_pin[CC] = 0; #1;
    chk("R11 cell feedback", N'(fb[CC]), N'(0));
  endtask

  initial begin
    tick(); tick();
    rst = 0;
    t_reset_r1();
    t_comb_r2();
    t_dreg_r3();
    t_treg_r4();
    t_latch_r5();
    t_clksel_r6();
    t_pol_r7();
    t_oe_r8();
    t_cap_r9();
    t_nocap_r10();
    t_fb_r11();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule